// File: doc/BRIEF.md
# Framed Voice Sample Serial Port

This block is the full-duplex serial data port of a voice transcoder. A bit clock and a frame strobe, both driven from outside, pace the port. Each frame moves one 8-bit PCM sample and one ADPCM code word in each direction. Three serial outputs carry data out of the block. The transmit PCM output carries the sample that feeds the encoder. The receive PCM output carries the decoder's output sample. The code output carries the encoded ADPCM word. Three serial inputs are turned back into parallel words, and each word comes with a one-cycle valid strobe. These inputs are the looped-back transmit PCM stream, the received code stream and the receive PCM stream.

A fast system clock runs the whole block. The bit clock, the frame strobe and the serial inputs pass through a synchronizer, and the block then acts on the edges of the bit clock that it detects. The bit clock may run without a break, or it may come in bursts that stop between frames. The code width (2, 3, 4 or 8 bits) comes from a mode field that is read once at each frame start. Separate mute controls set the transmitted code and the received code to zero. A power-down input forces fixed levels on the three outputs.

Top module: `sdp_serial_port`

## Requirements
- R1: A frame starts at a detected bit-clock rising edge where the strobe reads high and read low at the previous detected rising edge. Bit 0 (the MSB) is driven from that edge. Each later rising edge starts the next bit period.
- R2: The outputs change only in the system-clock cycle that follows a detected bit-clock rising edge, or while power-down is high. The transmit and receive PCM outputs send their 8-bit words MSB first.
- R3: The mode field sets the code width: 00 gives 4 bits, 01 gives 8, 10 gives 3 and 11 gives 2. The code output sends bits [w-1:0] of the transmit code, MSB first.
- R4: Every bit period after the last data bit of a lane drives that output low until the next frame start.
- R5: The looped-back transmit PCM input is sampled on falling edges during bit periods 0 to 7. After the eighth bit the word appears on enc_pcm_word, together with a valid pulse that lasts one system-clock cycle.
- R6: The received code input is sampled on falling edges during bit periods 0 to w-1. rx_code presents the code in its low w bits with the upper bits at zero, together with a one-cycle valid pulse.
- R7: The receive PCM input is sampled on the rising edge that starts each of bit periods 0 to 7, and it is delivered on dec_pcm_word with a one-cycle valid pulse.
- R8: Input bits that arrive after a lane's last data bit are ignored. Each input lane gives exactly one valid pulse per frame.
- R9: The mode, tx_mute and both transmit words are taken at frame start. A change to any of them later in the frame has no effect on that frame.
- R10: When tx_mute is high at frame start, every bit of the code output is zero for that frame.
- R11: When rx_mute is high in the cycle where the last code bit is captured, the delivered rx_code is zero.
- R12: While power_down is high, both PCM outputs go low and the code output goes high from the next cycle, no valid pulse is produced, and any partial frame is dropped.
- R13: The block works with a continuous bit clock and with a burst bit clock. Frame lengths run from 8 to 256 bit periods, and the strobe may be high for 1 to length-1 periods.
- R14: After reset all outputs are low and no valid pulse is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| power_down | input | 1 | Forces the output levels and stops the framing |
| bit_clk | input | 1 | Serial bit clock, continuous or burst |
| frame_sync | input | 1 | Frame strobe that marks the MSB period |
| code_mode | input | 2 | Selects the code width |
| tx_mute | input | 1 | Sends a zero code |
| rx_mute | input | 1 | Delivers a zero received code |
| tx_pcm_word | input | 8 | Sample to send on tx_pcm_sdo |
| rx_pcm_word | input | 8 | Decoded sample to send on rx_pcm_sdo |
| tx_code | input | 8 | Encoded code, right-aligned |
| tx_pcm_sdo | output | 1 | Serial transmit PCM output |
| rx_pcm_sdo | output | 1 | Serial receive PCM output |
| tx_code_sdo | output | 1 | Serial code output |
| tx_pcm_sdi | input | 1 | Looped-back transmit PCM input, sampled on falling edges |
| rx_code_sdi | input | 1 | Received code input, sampled on falling edges |
| rx_pcm_sdi | input | 1 | Receive PCM input, sampled on rising edges |
| enc_pcm_word | output | 8 | Deserialized transmit PCM word |
| enc_pcm_valid | output | 1 | One-cycle strobe for enc_pcm_word |
| dec_pcm_word | output | 8 | Deserialized receive PCM word |
| dec_pcm_valid | output | 1 | One-cycle strobe for dec_pcm_word |
| rx_code | output | 8 | Received code, right-aligned |
| rx_code_valid | output | 1 | One-cycle strobe for rx_code |

## Verification
Suppose the bit index or the latched width goes wrong inside the block. The serial outputs then show it within the same frame: a bit lands in the wrong period, or the trailing low bits start at the wrong place. The bench compares every output bit of every frame. A bad frame-start detector shows up as a missing or doubled valid pulse, or as a shifted word. That is visible a few system cycles after the last bit period of the frame. Mode changes in mid-frame, muting, and power-down with random junk after the data bits all expose stale or early sampling within one frame.

// File: rtl/sdp_pkg.sv
`timescale 1ns/1ps
package sdp_pkg;
    localparam int WORD_W = 8;
    localparam int CW_W   = $clog2(WORD_W + 1);

    typedef enum logic [1:0] {
        MODE_W4 = 2'b00,
        MODE_W8 = 2'b01,
        MODE_W3 = 2'b10,
        MODE_W2 = 2'b11
    } code_mode_e;

    function automatic logic [CW_W-1:0] code_width(input logic [1:0] mode);
        case (code_mode_e'(mode))
            MODE_W4: code_width = CW_W'(4);
            MODE_W8: code_width = CW_W'(8);
            MODE_W3: code_width = CW_W'(3);
            default: code_width = CW_W'(2);
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] width_mask(input logic [CW_W-1:0] width);
        logic [WORD_W-1:0] m;
        for (int i = 0; i < WORD_W; i++) begin
            m[i] = (i < int'(width));
        end
        return m;
    endfunction
endpackage

// File: rtl/sdp_pin_sync.sv
`timescale 1ns/1ps
module sdp_pin_sync #(
    parameter int N      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clk_pin,
    input  logic [N-1:0] data_pin,
    output logic [N-1:0] data_s,
    output logic         rise_ev,
    output logic         fall_ev
);
    typedef struct packed {
        logic [STAGES-1:0][N:0] chain;
        logic                   prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = {data_pin, clk_pin};
        for (int s = 1; s < STAGES; s++) begin
            st_d.chain[s] = st_q.chain[s-1];
        end
        st_d.prev = st_q.chain[STAGES-1][0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_s  = st_q.chain[STAGES-1][N:1];
    assign rise_ev =  st_q.chain[STAGES-1][0] & ~st_q.prev;
    assign fall_ev = ~st_q.chain[STAGES-1][0] &  st_q.prev;
endmodule

// File: rtl/sdp_serializer.sv
`timescale 1ns/1ps
module sdp_serializer
    import sdp_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            shift,
    input  logic            power_down,
    input  logic            pd_level,
    input  logic [W-1:0]    par,
    input  logic [CW_W-1:0] width,
    output logic            sdo
);
    typedef struct packed {
        logic [W-1:0] shreg;
        logic         out;
    } ser_st_t;

    ser_st_t st_d, st_q;
    logic [W-1:0] masked;
    logic [W-1:0] aligned;

    always_comb begin
        st_d    = st_q;
        masked  = par & width_mask(width);
        aligned = masked << (W - int'(width));
        if (power_down) begin
            st_d.shreg = '0;
            st_d.out   = pd_level;
        end else if (load) begin
            st_d.out   = aligned[W-1];
            st_d.shreg = {aligned[W-2:0], 1'b0};
        end else if (shift) begin
            st_d.out   = st_q.shreg[W-1];
            st_d.shreg = {st_q.shreg[W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sdo = st_q.out;
endmodule

// File: rtl/sdp_deserializer.sv
`timescale 1ns/1ps
module sdp_deserializer
    import sdp_pkg::*;
#(
    parameter int W     = WORD_W,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample,
    input  logic [IDX_W-1:0] idx,
    input  logic [CW_W-1:0]  width,
    input  logic             mute,
    input  logic             sdi,
    output logic [W-1:0]     word,
    output logic             valid
);
    typedef struct packed {
        logic [W-1:0] shreg;
        logic [W-1:0] word;
        logic         valid;
    } des_st_t;

    des_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (sample && (int'(idx) < int'(width))) begin
            st_d.shreg = {st_q.shreg[W-2:0], sdi};
            if (int'(idx) == int'(width) - 1) begin
                st_d.valid = 1'b1;
                st_d.word  = mute ? '0 : (st_d.shreg & width_mask(width));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word  = st_q.word;
    assign valid = st_q.valid;
endmodule

// File: rtl/sdp_serial_port.sv
`timescale 1ns/1ps
module sdp_serial_port
    import sdp_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int IDX_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              power_down,
    input  logic              bit_clk,
    input  logic              frame_sync,
    input  logic [1:0]        code_mode,
    input  logic              tx_mute,
    input  logic              rx_mute,
    input  logic [WORD_W-1:0] tx_pcm_word,
    input  logic [WORD_W-1:0] rx_pcm_word,
    input  logic [WORD_W-1:0] tx_code,
    output logic              tx_pcm_sdo,
    output logic              rx_pcm_sdo,
    output logic              tx_code_sdo,
    input  logic              tx_pcm_sdi,
    input  logic              rx_code_sdi,
    input  logic              rx_pcm_sdi,
    output logic [WORD_W-1:0] enc_pcm_word,
    output logic              enc_pcm_valid,
    output logic [WORD_W-1:0] dec_pcm_word,
    output logic              dec_pcm_valid,
    output logic [WORD_W-1:0] rx_code,
    output logic              rx_code_valid
);
    localparam int              N_IN    = 4;
    localparam logic [IDX_W-1:0] IDX_MAX = '1;
    localparam logic [CW_W-1:0]  PCM_W   = CW_W'(WORD_W);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [CW_W-1:0]  width;
        logic             sync_prev;
    } frm_st_t;

    localparam frm_st_t FRM_RESET = '{idx: IDX_MAX, width: PCM_W, sync_prev: 1'b0};

    frm_st_t st_d, st_q;

    logic [N_IN-1:0] pins_s;
    logic            rise_ev, fall_ev;
    logic            sync_s, txpcm_s, rxcode_s, rxpcm_s;
    logic            rise_act, fall_act, frame_start, shift_en;
    logic [CW_W-1:0] new_width, cur_width;
    logic [WORD_W-1:0] tx_code_eff;

    sdp_pin_sync #(.N(N_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_pin  (bit_clk),
        .data_pin ({rx_pcm_sdi, rx_code_sdi, tx_pcm_sdi, frame_sync}),
        .data_s   (pins_s),
        .rise_ev  (rise_ev),
        .fall_ev  (fall_ev)
    );

    assign {rxpcm_s, rxcode_s, txpcm_s, sync_s} = pins_s;

    always_comb begin
        rise_act    = rise_ev & ~power_down;
        fall_act    = fall_ev & ~power_down;
        frame_start = rise_act & sync_s & ~st_q.sync_prev;
        shift_en    = rise_act & ~frame_start;
        new_width   = code_width(code_mode);
        tx_code_eff = tx_mute ? '0 : tx_code;

        st_d = st_q;
        if (power_down) begin
            st_d = FRM_RESET;
        end else if (rise_act) begin
            st_d.sync_prev = sync_s;
            if (frame_start) begin
                st_d.idx   = '0;
                st_d.width = new_width;
            end else if (st_q.idx != IDX_MAX) begin
                st_d.idx = st_q.idx + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FRM_RESET;
        else        st_q <= st_d;
    end

    assign cur_width = st_q.width;

    sdp_serializer u_ser_txpcm (
        .clk(clk), .rst_n(rst_n), .load(frame_start), .shift(shift_en),
        .power_down(power_down), .pd_level(1'b0), .par(tx_pcm_word),
        .width(PCM_W), .sdo(tx_pcm_sdo)
    );

    sdp_serializer u_ser_rxpcm (
        .clk(clk), .rst_n(rst_n), .load(frame_start), .shift(shift_en),
        .power_down(power_down), .pd_level(1'b0), .par(rx_pcm_word),
        .width(PCM_W), .sdo(rx_pcm_sdo)
    );

    sdp_serializer u_ser_code (
        .clk(clk), .rst_n(rst_n), .load(frame_start), .shift(shift_en),
        .power_down(power_down), .pd_level(1'b1), .par(tx_code_eff),
        .width(new_width), .sdo(tx_code_sdo)
    );

    sdp_deserializer #(.IDX_W(IDX_W)) u_des_enc (
        .clk(clk), .rst_n(rst_n), .sample(fall_act), .idx(st_q.idx),
        .width(PCM_W), .mute(1'b0), .sdi(txpcm_s),
        .word(enc_pcm_word), .valid(enc_pcm_valid)
    );

    sdp_deserializer #(.IDX_W(IDX_W)) u_des_code (
        .clk(clk), .rst_n(rst_n), .sample(fall_act), .idx(st_q.idx),
        .width(st_q.width), .mute(rx_mute), .sdi(rxcode_s),
        .word(rx_code), .valid(rx_code_valid)
    );

    sdp_deserializer #(.IDX_W(IDX_W)) u_des_dec (
        .clk(clk), .rst_n(rst_n), .sample(rise_act), .idx(st_d.idx),
        .width(PCM_W), .mute(1'b0), .sdi(rxpcm_s),
        .word(dec_pcm_word), .valid(dec_pcm_valid)
    );
endmodule

// File: rtl/sdp_serial_port_chk.sv
`timescale 1ns/1ps
module sdp_serial_port_chk
    import sdp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              power_down,
    input logic              rise_ev,
    input logic [CW_W-1:0]   cur_width,
    input logic              rx_mute,
    input logic              tx_pcm_sdo,
    input logic              rx_pcm_sdo,
    input logic              tx_code_sdo,
    input logic              enc_pcm_valid,
    input logic              dec_pcm_valid,
    input logic              rx_code_valid,
    input logic [WORD_W-1:0] rx_code
);
    AST_PD_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
        power_down |=> (!tx_pcm_sdo && !rx_pcm_sdo && tx_code_sdo)); // R12

    AST_PD_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        power_down |=> (!enc_pcm_valid && !dec_pcm_valid && !rx_code_valid)); // R12

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise_ev && !power_down) |=> ($stable(tx_pcm_sdo) && $stable(rx_pcm_sdo) && $stable(tx_code_sdo))); // R2

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_pcm_valid || dec_pcm_valid || rx_code_valid) |=> !(enc_pcm_valid && $past(enc_pcm_valid)) && !(rx_code_valid && $past(rx_code_valid))); // R5

    AST_RX_MUTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_code_valid && $past(rx_mute)) |-> (rx_code == '0)); // R11

    AST_CODE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rx_code_valid |-> ((rx_code & ~width_mask($past(cur_width))) == '0)); // R6
endmodule

bind sdp_serial_port sdp_serial_port_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .power_down    (power_down),
    .rise_ev       (rise_ev),
    .cur_width     (cur_width),
    .rx_mute       (rx_mute),
    .tx_pcm_sdo    (tx_pcm_sdo),
    .rx_pcm_sdo    (rx_pcm_sdo),
    .tx_code_sdo   (tx_code_sdo),
    .enc_pcm_valid (enc_pcm_valid),
    .dec_pcm_valid (dec_pcm_valid),
    .rx_code_valid (rx_code_valid),
    .rx_code       (rx_code)
);

// File: tb/test_sdp_serial_port.sv
`timescale 1ns/1ps
module test_sdp_serial_port;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic power_down = 1'b0, bit_clk = 1'b0, frame_sync = 1'b0;
    logic [1:0] code_mode = 2'b00;
    logic tx_mute = 1'b0, rx_mute = 1'b0;
    logic [7:0] tx_pcm_word = '0, rx_pcm_word = '0, tx_code = '0;
    logic tx_pcm_sdo, rx_pcm_sdo, tx_code_sdo;
    logic tx_pcm_sdi = 1'b0, rx_code_sdi = 1'b0, rx_pcm_sdi = 1'b0;
    logic [7:0] enc_pcm_word, dec_pcm_word, rx_code;
    logic enc_pcm_valid, dec_pcm_valid, rx_code_valid;

    int n_cmp = 0, n_bad = 0;
    int enc_cnt = 0, dec_cnt = 0, code_cnt = 0;
    logic [7:0] enc_got = '0, dec_got = '0, code_got = '0;
    bit finished = 0;

    always #5 clk = ~clk;

    sdp_serial_port i_sdp_serial_port (.*);

    always @(negedge clk) begin
        if (enc_pcm_valid) begin enc_cnt++; enc_got = enc_pcm_word; end
        if (dec_pcm_valid) begin dec_cnt++; dec_got = dec_pcm_word; end
        if (rx_code_valid) begin code_cnt++; code_got = rx_code; end
    end

    function automatic int width_of(input logic [1:0] m);
        case (m)
            2'b00: return 4;
            2'b01: return 8;
            2'b10: return 3;
            default: return 2;
        endcase
    endfunction

    function automatic logic [7:0] low_mask(input int w);
        return 8'((16'h1 << w) - 1);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic half();
        repeat (4) @(posedge clk);
        #1;
    endtask

    task automatic run_frame(input int len, input int sw, input bit burst, input logic [1:0] md,
                             input bit tmute, input bit rmute, input bit pd, input bit flip);
        int w;
        logic [7:0] pcm_t, pcm_r, code_t, enc_in, dec_in, code_in;
        logic e_tp, e_rp, e_cd;
        w       = width_of(md);
        pcm_t   = 8'($urandom); pcm_r = 8'($urandom); code_t = 8'($urandom);
        enc_in  = 8'($urandom); dec_in = 8'($urandom); code_in = 8'($urandom);
        code_mode = md; tx_mute = tmute; rx_mute = rmute; power_down = pd;
        tx_pcm_word = pcm_t; rx_pcm_word = pcm_r; tx_code = code_t;
        rx_pcm_sdi = dec_in[7];
        enc_cnt = 0; dec_cnt = 0; code_cnt = 0;
        for (int b = 0; b < len; b++) begin
            bit_clk = 1'b1;
            if (b == 0)  frame_sync = 1'b1;
            if (b == sw) frame_sync = 1'b0;
            tx_pcm_sdi  = (b < 8) ? enc_in[7-b] : 1'($urandom);
            rx_code_sdi = (b < w) ? code_in[w-1-b] : 1'($urandom);
            if (flip && b == 1) begin
                // R9: late changes of mode, mute and words must not matter
                code_mode = ~md; tx_mute = ~tmute;
                tx_pcm_word = ~pcm_t; rx_pcm_word = ~pcm_r; tx_code = ~code_t;
            end
            half();
            e_tp = pd ? 1'b0 : ((b < 8) ? pcm_t[7-b] : 1'b0);
            e_rp = pd ? 1'b0 : ((b < 8) ? pcm_r[7-b] : 1'b0);
            e_cd = pd ? 1'b1 : ((b < w && !tmute) ? code_t[w-1-b] : 1'b0);
            check(tx_pcm_sdo == e_tp, pd ? "R12 tx pcm pd" : (b < 8 ? "R2 R1 tx pcm bit" : "R4 tx pcm tail"), tx_pcm_sdo, e_tp);
            check(rx_pcm_sdo == e_rp, pd ? "R12 rx pcm pd" : (b < 8 ? "R2 rx pcm bit" : "R4 rx pcm tail"), rx_pcm_sdo, e_rp);
            check(tx_code_sdo == e_cd, pd ? "R12 code pd" : (tmute ? "R10 muted code" : (b < w ? "R3 code bit" : "R4 code tail")), tx_code_sdo, e_cd);
            bit_clk = 1'b0;
            rx_pcm_sdi = (b + 1 < 8) ? dec_in[6-b] : 1'($urandom);
            half();
        end
        if (burst) repeat (20) @(posedge clk);
        #1;
        if (pd) begin
            check(enc_cnt == 0 && dec_cnt == 0 && code_cnt == 0, "R12 no valid", enc_cnt + dec_cnt + code_cnt, 0);
        end else begin
            check(enc_cnt == 1, "R8 R5 enc valid count", enc_cnt, 1);
            check(enc_got == enc_in, "R5 enc word", enc_got, enc_in);
            check(dec_cnt == 1, "R8 R7 dec valid count", dec_cnt, 1);
            check(dec_got == dec_in, "R7 dec word", dec_got, dec_in);
            check(code_cnt == 1, "R8 R6 code valid count", code_cnt, 1);
            check(code_got == (rmute ? 8'h00 : (code_in & low_mask(w))),
                  rmute ? "R11 rx muted code" : (burst ? "R13 R6 rx code" : "R6 rx code"),
                  code_got, rmute ? 0 : int'(code_in & low_mask(w)));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(posedge clk);
        #1;
        // R14: reset state
        check(!tx_pcm_sdo && !rx_pcm_sdo && !tx_code_sdo, "R14 outputs low", {tx_pcm_sdo, rx_pcm_sdo, tx_code_sdo}, 0);
        check(!enc_pcm_valid && !dec_pcm_valid && !rx_code_valid, "R14 no valid", 0, 0);
        rst_n = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        // Directed: every mode, minimum frame, burst and continuous (R3, R13)
        run_frame(8, 1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
        run_frame(8, 7, 1'b0, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0);
        run_frame(12, 3, 1'b1, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0);
        run_frame(16, 15, 1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
        // R10 / R11 mutes
        run_frame(10, 2, 1'b0, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0);
        // R9 mid-frame changes
        run_frame(12, 1, 1'b0, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1);
        run_frame(9, 4, 1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 1'b1);
        // R12 power-down frame, then recovery
        run_frame(10, 1, 1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0);
        power_down = 1'b0;
        run_frame(10, 1, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
        // R13 long frame
        run_frame(256, 128, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
        // Random frames
        for (int k = 0; k < 40; k++) begin
            int len, sw;
            len = 8 + int'($urandom_range(32));
            sw  = 1 + int'($urandom_range(len - 2));
            run_frame(len, sw, 1'($urandom), 2'($urandom), ($urandom_range(3) == 0),
                      ($urandom_range(3) == 0), 1'b0, ($urandom_range(4) == 0));
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule